// File: doc/BRIEF.md
# UART receive error interrupt tracker

This block holds the characters a UART receiver has assembled, together with four error tags for each one: overrun, parity, framing and break. It presents the host with the byte at the head of the queue. It also builds the line-status byte. That byte carries a data-ready bit, the error tags of the head byte only, and a summary bit that stays set while any tagged byte is still queued.

The line-status interrupt fires twice for a bad character. The first time is when the character arrives, even if clean bytes are still ahead of it. The second time is when a read brings it to the head of the queue, so that the host can see which error it carried. Reading the line-status byte clears a pending request. An enable input gates the request pin and has no effect on the status.

When a byte arrives while the queue is full, the byte is dropped. The overrun tag is then set on the newest byte that was kept.

Top module: `uart_rx_err_tracker`

## Requirements
- R1: After reset the queue is empty, `lsr` is 0x00, `rd_data` is 0x00 and `irq` is low.
- R2: Bytes leave in arrival order. `rd_data` shows the head byte, or 0x00 when the queue is empty. `lsr` bit 0 is set while the queue holds a byte. A data read on an empty queue changes nothing.
- R3: `lsr` bits 1, 2, 3 and 4 carry the overrun, parity, framing and break tags of the head byte only. They are zero when the queue is empty. Bits 5 and 6 are always zero.
- R4: `lsr` bit 7 is set exactly while at least one queued byte carries a nonzero tag.
- R5: Storing a byte with any tag set makes the request pending on the next cycle. `irq` equals pending AND `irq_en`.
- R6: A line-status read clears the pending request. If a new cause arrives in the same cycle, the request stays pending.
- R7: A data read whose next head byte carries a tag makes the request pending again.
- R8: While `irq_en` is low, `irq` stays low. The status bits and the pending state keep updating, so raising `irq_en` shows a request that is still pending.
- R9: A write to a full queue with no read in the same cycle drops the byte. It sets the overrun tag of the newest stored byte and makes the request pending.
- R10: The queue holds exactly DEPTH bytes (16 by default). A write and a read in the same cycle on a full queue are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Received-character strobe, pulsed at the stop bit |
| wr_data | input | DW | Received character |
| wr_ovr | input | 1 | Overrun flag for the character |
| wr_par | input | 1 | Parity error flag |
| wr_frm | input | 1 | Framing error flag |
| wr_brk | input | 1 | Break flag |
| rd_data_en | input | 1 | Host read of the data register (pops the head) |
| rd_lsr_en | input | 1 | Host read of the line-status byte |
| irq_en | input | 1 | Line-status interrupt enable |
| rd_data | output | DW | Head byte |
| lsr | output | 8 | Line-status byte |
| irq | output | 1 | Line-status interrupt request |

## Verification
The bench replays the two-byte case of a clean byte ahead of a parity-tagged one. A design that showed the tags of the newest byte would report bit 2 too early. A design that skipped the second request would leave `irq` low once the clean byte is read. The bench fills the queue and writes one more byte to check that the extra byte is lost and the overrun tag lands on the last kept byte. It also checks that a status read in the same cycle as a new error leaves the request pending, and that a low enable hides the request without freezing the status. Random traffic is compared every cycle against a shifting-queue model, which catches a summary count that drifts when tagged entries are pushed and popped together.

// File: rtl/uart_rx_err_tracker.sv
module uart_rx_err_tracker #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_ovr,
  input  logic          wr_par,
  input  logic          wr_frm,
  input  logic          wr_brk,
  input  logic          rd_data_en,
  input  logic          rd_lsr_en,
  input  logic          irq_en,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    lsr,
  output logic          irq
);

  localparam int TW = 4;
  localparam int EW = DW + TW;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] back(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] cnt, ecnt;
  logic          pend;

  wire [TW-1:0] wtag     = {wr_brk, wr_frm, wr_par, wr_ovr};
  wire          empty    = (cnt == '0);
  wire          full     = (cnt == CW'(DEPTH));
  wire          pop      = rd_data_en & ~empty;
  wire          push     = wr_en & (~full | pop);
  wire          ovf      = wr_en & full & ~pop;
  wire [AW-1:0] rnext    = bump(rptr);
  wire [AW-1:0] wlast    = back(wptr);
  wire [TW-1:0] head_tag = mem[rptr][EW-1:DW];
  wire [TW-1:0] next_tag = mem[rnext][EW-1:DW];
  wire          last_cln = (mem[wlast][EW-1:DW] == '0);

  wire ev_arr  = push & (|wtag);
  wire ev_head = pop & (cnt > CW'(1)) & (|next_tag);
  wire set_req = ev_arr | ev_head | ovf;

  wire ecnt_up = ev_arr | (ovf & last_cln);
  wire ecnt_dn = pop & (|head_tag);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {wtag, wr_data};
    else if (ovf) mem[wlast][DW] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
      ecnt <= '0;
      pend <= 1'b0;
    end else begin
      if (pop)  rptr <= rnext;
      if (push) wptr <= bump(wptr);
      cnt  <= cnt + CW'(push) - CW'(pop);
      ecnt <= ecnt + CW'(ecnt_up) - CW'(ecnt_dn);
      if (set_req)        pend <= 1'b1;
      else if (rd_lsr_en) pend <= 1'b0;
    end
  end

  assign rd_data = empty ? '0 : mem[rptr][DW-1:0];
  assign lsr     = {(ecnt != '0), 2'b00, (empty ? 4'b0000 : head_tag), ~empty};
  assign irq     = pend & irq_en;

  a_r5_arrival_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && (wr_ovr || wr_par || wr_frm || wr_brk)) |=> pend);

  a_r6_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_en && !wr_en && !rd_data_en) |=> !pend);

  a_r7_head_resets_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_en && cnt > CW'(1) && mem[rnext][EW-1:DW] != '0) |=> pend);

  a_r2_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_en && empty && !wr_en) |=> $stable(cnt) && $stable(rptr));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r4_tagged_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= cnt);

  a_r8_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_data_en) |=> $stable(cnt) && pend);

endmodule

// File: tb/uart_rx_err_tracker_bench.sv
`timescale 1ns/1ps
module uart_rx_err_tracker_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ovr = 1'b0, wr_par = 1'b0, wr_frm = 1'b0, wr_brk = 1'b0;
  logic       rd_data_en = 1'b0, rd_lsr_en = 1'b0, irq_en = 1'b0;
  logic [7:0] rd_data, lsr;
  logic       irq;

  always #2.5 clk = ~clk;

  uart_rx_err_tracker #(.DEPTH(DEPTH), .DW(8)) u_uart_rx_err_tracker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ovr(wr_ovr), .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk),
    .rd_data_en(rd_data_en), .rd_lsr_en(rd_lsr_en), .irq_en(irq_en),
    .rd_data(rd_data), .lsr(lsr), .irq(irq));

  int errs = 0, checks = 0;
  bit done = 0;

  logic [7:0] qd [DEPTH];
  logic [3:0] qt [DEPTH];
  int   qn = 0;
  logic mp = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lsr();
    bit anyt = 0;
    for (int i = 0; i < qn; i++) if (qt[i] != 0) anyt = 1;
    return {anyt, 2'b00, (qn > 0 ? qt[0] : 4'h0), (qn > 0)};
  endfunction

  function automatic logic [7:0] exp_data();
    return (qn > 0) ? qd[0] : 8'h00;
  endfunction

  task automatic model(input bit w, input logic [7:0] d, input logic [3:0] t,
                       input bit r, input bit s);
    bit setr = 0;
    bit popd = (r && qn > 0);
    if (w && qn == DEPTH && !popd) begin
      qt[qn-1][0] = 1'b1;
      setr = 1;
    end
    if (popd) begin
      for (int i = 0; i < DEPTH - 1; i++) begin qd[i] = qd[i+1]; qt[i] = qt[i+1]; end
      qn--;
      if (qn > 0 && qt[0] != 0) setr = 1;
    end
    if (w && qn < DEPTH) begin
      qd[qn] = d; qt[qn] = t; qn++;
      if (t != 0) setr = 1;
    end
    if (setr) mp = 1'b1;
    else if (s) mp = 1'b0;
  endtask

  task automatic cmp_all();
    logic [7:0] el = exp_lsr();
    chk(rd_data == exp_data(), "R2", "head byte", rd_data, exp_data());
    chk(lsr[0] == el[0], "R2", "data ready", lsr[0], el[0]);
    chk(lsr[6:1] == el[6:1], "R3", "head tags", lsr[6:1], el[6:1]);
    chk(lsr[7] == el[7], "R4", "error summary", lsr[7], el[7]);
    chk(irq == (mp & irq_en), "R5", "irq", irq, mp & irq_en);
  endtask

  task automatic step(input bit w, input logic [7:0] d, input logic [3:0] t,
                      input bit r, input bit s);
    wr_en = w; wr_data = d;
    {wr_brk, wr_frm, wr_par, wr_ovr} = t;
    rd_data_en = r; rd_lsr_en = s;
    model(w, d, t, r, s);
    @(negedge clk);
    wr_en = 0; rd_data_en = 0; rd_lsr_en = 0;
    cmp_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lsr == 8'h00, "R1", "reset lsr", lsr, 8'h00);
    chk(irq == 1'b0, "R1", "reset irq", irq, 0);
    chk(rd_data == 8'h00, "R1", "reset data", rd_data, 0);

    irq_en = 1'b1;
    step(1, 8'h55, 4'h0, 0, 0);
    chk(irq == 1'b0, "R5", "clean byte no irq", irq, 0);
    step(1, 8'hAA, 4'h2, 0, 0);
    chk(lsr == 8'h81, "R3", "only summary while clean head", lsr, 8'h81);
    chk(irq == 1'b1, "R5", "arrival irq", irq, 1);
    step(0, 0, 0, 0, 1);
    chk(irq == 1'b0, "R6", "lsr read clears", irq, 0);
    step(0, 0, 0, 1, 0);
    chk(lsr == 8'h85, "R7", "parity at head", lsr, 8'h85);
    chk(irq == 1'b1, "R7", "second irq", irq, 1);
    chk(rd_data == 8'hAA, "R2", "head data", rd_data, 8'hAA);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    chk(lsr == 8'h00, "R4", "summary clears when drained", lsr, 0);
    step(0, 0, 0, 1, 0);
    chk(lsr == 8'h00, "R2", "empty read ignored", lsr, 0);

    step(1, 8'h11, 4'h4, 0, 1);
    chk(irq == 1'b1, "R6", "new cause beats clear", irq, 1);
    step(0, 0, 0, 1, 1);

    irq_en = 1'b0;
    step(1, 8'h22, 4'h8, 0, 0);
    chk(irq == 1'b0, "R8", "masked irq", irq, 0);
    chk(lsr == 8'h91, "R8", "status updates while masked", lsr, 8'h91);
    irq_en = 1'b1;
    #0.1;
    chk(irq == 1'b1, "R8", "pending shows on enable", irq, 1);
    step(0, 0, 0, 1, 1);

    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h30 + i), 4'h0, 0, 0);
    chk(lsr == 8'h01, "R10", "full of clean bytes", lsr, 8'h01);
    step(1, 8'hEE, 4'h0, 0, 0);
    chk(lsr == 8'h81, "R9", "overrun tag counted", lsr, 8'h81);
    chk(irq == 1'b1, "R9", "overrun irq", irq, 1);
    step(1, 8'h77, 4'h0, 1, 1);
    chk(rd_data == 8'h31, "R10", "simultaneous read/write on full", rd_data, 8'h31);
    for (int i = 0; i < DEPTH - 2; i++) step(0, 0, 0, 1, 0);
    chk(lsr == 8'h83, "R9", "overrun on last kept byte", lsr, 8'h83);
    chk(rd_data == 8'h3F, "R9", "dropped byte absent", rd_data, 8'h3F);
    step(0, 0, 0, 1, 1);
    chk(rd_data == 8'h77, "R10", "byte after full write kept", rd_data, 8'h77);
    step(0, 0, 0, 1, 1);

    for (int n = 0; n < 4000; n++) begin
      bit w = ($urandom % 100) < 50;
      bit r = ($urandom % 100) < 45;
      bit s = ($urandom % 100) < 20;
      logic [3:0] t = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      if (($urandom % 64) == 0) irq_en = ~irq_en;
      step(w, 8'($urandom), t, r, s);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule